// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects up to 32 interrupt requests and drives one active-low interrupt line toward a processor. Each source has a mode word with a trigger type and a 3-bit priority, and a vector word the processor gets back when it claims that source. A shared write-one command word enables sources, another disables them, and a third discards latched edges. A readable mask word shows which sources are currently enabled. Requests are synchronized by a two-flop chain, so the inputs may be asynchronous.

The processor claims an interrupt by reading the claim register. The read returns the vector of the best qualifying source and marks that source's priority as in service on an internal eight-level priority stack. While a level is in service, only strictly higher priorities can pull the interrupt line low. Writing the end-of-service register with any data retires the innermost level. A claim read with nothing qualifying returns a programmable spurious vector and leaves the stack untouched.

Sources named as external in a parameter mask may use all four trigger types. Internal sources can only be active-high level or rising edge.

Top module: `vic_core`

## Requirements
- R1: After reset all sources are disabled (mask reads 0), every mode and vector word reads 0, the spurious vector is 0, the priority stack is empty and `irq_n` is 1.
- R2: Writing the enable command (address 0x42) sets the mask bits where data holds 1, and writing the disable command (address 0x43) clears them. Data bits at 0 change nothing. The mask reads back at address 0x41.
- R3: The mode word of source i is at address i, with priority in bits [2:0] and trigger type in bits [5:4]. The type codes are 00 level high, 01 rising edge, 10 level low and 11 falling edge. The word reads back as written on an external source.
- R4: On an internal source, bit 5 of the mode word is stored as 0. A written 10 reads back as 00 and a written 11 reads back as 01.
- R5: A read of the claim register (address 0x40) returns the vector word (address 0x20+i) of the enabled, active source with the highest priority above the stack top. Ties go to the lowest source number.
- R6: With no qualifying source, a claim read returns the spurious vector (address 0x46) and does not change the priority stack.
- R7: `irq_n` is 0 exactly when some enabled, active source has a priority strictly above the stack top, or any priority when the stack is empty.
- R8: A claim read that selects a source pushes its priority. A write to address 0x45 pops the innermost level, and such a write with an empty stack has no effect. Eight of these writes empty a full stack.
- R9: Edge-type sources latch a pending flag. The flag is cleared by a claim read that selects the source, or by a 1 in its bit of the clear command (address 0x44). An all-ones clear drops every source's flag.
- R10: Level-type sources follow their input after two clock cycles of synchronization and are not latched: a level request disappears two cycles after its input goes inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Raw interrupt request inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (claim side effects on the clock edge) |
| bus_addr | input | 7 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
The bench keeps the defaults: 32 sources, a 3-bit priority and an external mask that marks sources 28 to 31. With these values one bench covers both the coerced internal trigger types and the falling and low-level types on external sources. The 3-bit priority gives the full eight-level stack, so the bench can claim at all eight levels in rising order and then retire them one by one. It can also reach the ninth, ignored end-of-service write.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam int ADDR_W = 7;

   localparam logic [1:0] TRG_LVL_HI = 2'b00;
   localparam logic [1:0] TRG_RISE   = 2'b01;
   localparam logic [1:0] TRG_LVL_LO = 2'b10;
   localparam logic [1:0] TRG_FALL   = 2'b11;

   localparam logic [ADDR_W-1:0] A_CLAIM = 7'h40;
   localparam logic [ADDR_W-1:0] A_MASK  = 7'h41;
   localparam logic [ADDR_W-1:0] A_ENA   = 7'h42;
   localparam logic [ADDR_W-1:0] A_DIS   = 7'h43;
   localparam logic [ADDR_W-1:0] A_CLR   = 7'h44;
   localparam logic [ADDR_W-1:0] A_EOI   = 7'h45;
   localparam logic [ADDR_W-1:0] A_SPU   = 7'h46;

   localparam int TYPE_LSB = 4;
endpackage

// File: rtl/vic_src_cond.sv
module vic_src_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       raw,
   input  logic [1:0] trig,
   input  logic       clr,
   output logic       active
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic prev_q, pend_q, s, edge_hit, lvl;

   assign s = sync_q[SYNC_STAGES-1];

   always_comb begin
      edge_hit = 1'b0;
      if (trig[0])
         edge_hit = trig[1] ? (~s & prev_q) : (s & ~prev_q);
      lvl    = trig[1] ? ~s : s;
      active = trig[0] ? pend_q : lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
         prev_q <= s;
         pend_q <= edge_hit | (pend_q & ~clr);
      end
   end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
   parameter int NSRC   = 32,
   parameter int PRIO_W = 3,
   localparam int IDX_W = $clog2(NSRC)
) (
   input  logic [NSRC-1:0]             req,
   input  logic [NSRC-1:0][PRIO_W-1:0] prio,
   input  logic                        floor_vld,
   input  logic [PRIO_W-1:0]           floor_prio,
   output logic                        hit,
   output logic [IDX_W-1:0]            idx,
   output logic [PRIO_W-1:0]           best
);
   always_comb begin
      hit  = 1'b0;
      idx  = '0;
      best = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (req[i] && (!floor_vld || prio[i] > floor_prio) &&
             (!hit || prio[i] > best)) begin
            hit  = 1'b1;
            idx  = i[IDX_W-1:0];
            best = prio[i];
         end
      end
   end
endmodule

// File: rtl/vic_prio_stack.sv
module vic_prio_stack #(
   parameter int PRIO_W = 3,
   localparam int LEVELS = 1 << PRIO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [PRIO_W-1:0] push_lvl,
   input  logic              pop,
   output logic              nonempty,
   output logic [PRIO_W-1:0] top,
   output logic [LEVELS-1:0] levels
);
   logic [LEVELS-1:0] lvl_q, top_oh, push_oh;

   always_comb begin
      top = '0;
      for (int l = 0; l < LEVELS; l++)
         if (lvl_q[l]) top = l[PRIO_W-1:0];
      nonempty = |lvl_q;
      top_oh   = nonempty ? (LEVELS'(1) << top) : '0;
      push_oh  = push ? (LEVELS'(1) << push_lvl) : '0;
   end

   assign levels = lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= (lvl_q & ~(pop ? top_oh : '0)) | push_oh;
   end
endmodule

// File: rtl/vic_core.sv
module vic_core
   import vic_pkg::*;
#(
   parameter int          NSRC        = 32,
   parameter int          PRIO_W      = 3,
   parameter int          VEC_W       = 32,
   parameter int          SYNC_STAGES = 2,
   parameter logic [31:0] EXT_MASK    = 32'hF000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_in,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_n
);
   localparam int IDX_W  = $clog2(NSRC);
   localparam int LEVELS = 1 << PRIO_W;

   if (NSRC < 2 || NSRC > 32) begin : g_chk_nsrc
      $error("NSRC must lie in 2..32");
   end
   if (PRIO_W < 1 || PRIO_W > 4) begin : g_chk_prio
      $error("PRIO_W must lie in 1..4");
   end
   if (VEC_W < 1 || VEC_W > 32) begin : g_chk_vec
      $error("VEC_W must lie in 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NSRC-1:0][PRIO_W-1:0] prio_all;
   logic [NSRC-1:0][31:0]       mode_word, vec_word;
   logic [NSRC-1:0]             active, clr_pend, req, ena_bits, dis_bits;
   logic [NSRC-1:0]             mask_q;
   logic [VEC_W-1:0]            spu_q;
   logic                        mode_wr, vec_wr, claim_rd, eoi_wr, clr_wr;
   logic                        arb_hit, stk_nonempty;
   logic [IDX_W-1:0]            arb_idx;
   logic [PRIO_W-1:0]           arb_prio, stk_top;
   logic [LEVELS-1:0]           stk_levels;

   assign mode_wr  = bus_wr && (bus_addr[6:5] == 2'b00);
   assign vec_wr   = bus_wr && (bus_addr[6:5] == 2'b01);
   assign claim_rd = bus_rd && (bus_addr == A_CLAIM);
   assign eoi_wr   = bus_wr && (bus_addr == A_EOI);
   assign clr_wr   = bus_wr && (bus_addr == A_CLR);
   assign ena_bits = (bus_wr && bus_addr == A_ENA) ? bus_wdata[NSRC-1:0] : '0;
   assign dis_bits = (bus_wr && bus_addr == A_DIS) ? bus_wdata[NSRC-1:0] : '0;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic [PRIO_W-1:0] prio_r;
      logic [1:0]        trig_r, trig_in;
      logic [VEC_W-1:0]  vec_r;

      if (EXT_MASK[i]) begin : g_ext
         assign trig_in = bus_wdata[TYPE_LSB+1:TYPE_LSB];
      end else begin : g_int
         assign trig_in = {1'b0, bus_wdata[TYPE_LSB]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_r <= '0;
            trig_r <= TRG_LVL_HI;
            vec_r  <= '0;
         end else begin
            if (mode_wr && bus_addr[4:0] == 5'(i)) begin
               prio_r <= bus_wdata[PRIO_W-1:0];
               trig_r <= trig_in;
            end
            if (vec_wr && bus_addr[4:0] == 5'(i))
               vec_r <= bus_wdata[VEC_W-1:0];
         end
      end

      always_comb begin
         mode_word[i] = '0;
         mode_word[i][TYPE_LSB+1:TYPE_LSB] = trig_r;
         mode_word[i][PRIO_W-1:0] = prio_r;
      end
      assign vec_word[i] = 32'(vec_r);
      assign prio_all[i] = prio_r;
      assign clr_pend[i] = (clr_wr && bus_wdata[i]) ||
                           (claim_rd && arb_hit && arb_idx == IDX_W'(i));

      vic_src_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw    (src_in[i]),
         .trig   (trig_r),
         .clr    (clr_pend[i]),
         .active (active[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         spu_q  <= '0;
      end else begin
         mask_q <= (mask_q | ena_bits) & ~dis_bits;
         if (bus_wr && bus_addr == A_SPU) spu_q <= bus_wdata[VEC_W-1:0];
      end
   end

   assign req = mask_q & active;

   vic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
      .req        (req),
      .prio       (prio_all),
      .floor_vld  (stk_nonempty),
      .floor_prio (stk_top),
      .hit        (arb_hit),
      .idx        (arb_idx),
      .best       (arb_prio)
   );

   vic_prio_stack #(.PRIO_W(PRIO_W)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (claim_rd && arb_hit),
      .push_lvl (arb_prio),
      .pop      (eoi_wr),
      .nonempty (stk_nonempty),
      .top      (stk_top),
      .levels   (stk_levels)
   );

   assign irq_n = ~arb_hit;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr[6:5] == 2'b00) begin
         if (32'(bus_addr[4:0]) < NSRC) bus_rdata = mode_word[bus_addr[IDX_W-1:0]];
      end else if (bus_addr[6:5] == 2'b01) begin
         if (32'(bus_addr[4:0]) < NSRC) bus_rdata = vec_word[bus_addr[IDX_W-1:0]];
      end else if (bus_addr == A_CLAIM) begin
         bus_rdata = arb_hit ? vec_word[arb_idx] : 32'(spu_q);
      end else if (bus_addr == A_MASK) begin
         bus_rdata = 32'(mask_q);
      end else if (bus_addr == A_SPU) begin
         bus_rdata = 32'(spu_q);
      end
   end
endmodule

// File: rtl/vic_core_chk.sv
module vic_core_chk
   import vic_pkg::*;
#(
   parameter int NSRC   = 32,
   parameter int PRIO_W = 3,
   parameter int VEC_W  = 32,
   localparam int LEVELS = 1 << PRIO_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              irq_n,
   input logic [NSRC-1:0]   mask_q,
   input logic [NSRC-1:0]   req,
   input logic [LEVELS-1:0] levels,
   input logic [VEC_W-1:0]  spu_q,
   input logic              arb_hit,
   input logic [PRIO_W-1:0] arb_prio
);
   logic claim_rd, eoi_wr;
   assign claim_rd = bus_rd && bus_addr == A_CLAIM;
   assign eoi_wr   = bus_wr && bus_addr == A_EOI;

   // R7
   irq_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (req != '0));

   // R7
   irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |-> irq_n);

   // R2
   ena_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_ENA) |=>
      ((mask_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

   // R2
   dis_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_DIS) |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == '0));

   // R6
   spu_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_rd && irq_n) |-> (bus_rdata == 32'(spu_q)));

   // R8
   eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && !claim_rd && levels == '0) |=> (levels == '0));

   // R8
   stk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!claim_rd && !eoi_wr) |=> $stable(levels));

   // R8
   push_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_rd && arb_hit && !eoi_wr) |=> levels[$past(arb_prio)]);
endmodule

bind vic_core vic_core_chk #(.NSRC(NSRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) i_vic_core_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_n     (irq_n),
   .mask_q    (mask_q),
   .req       (req),
   .levels    (stk_levels),
   .spu_q     (spu_q),
   .arb_hit   (arb_hit),
   .arb_prio  (arb_prio)
);

// File: tb/test_vic_core.sv
module test_vic_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_in = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_n;

   int total = 0, bad = 0;
   logic [2:0]  b_prio [16];
   logic [31:0] b_vec  [16];
   logic [15:0] b_mask;
   logic [7:0]  b_stk;
   logic [31:0] rv;

   always #2 clk = ~clk;

   vic_core i_vic_core (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] model_sel(input logic [15:0] act);
      // returns {hit, 2'b0, idx[4:0]}
      logic       hit = 1'b0;
      logic [4:0] idx = '0;
      logic [2:0] best = '0;
      logic       fv = |b_stk;
      logic [2:0] top = '0;
      for (int l = 0; l < 8; l++) if (b_stk[l]) top = 3'(l);
      for (int i = 0; i < 16; i++)
         if (act[i] && (!fv || b_prio[i] > top) && (!hit || b_prio[i] > best)) begin
            hit = 1'b1; idx = 5'(i); best = b_prio[i];
         end
      return {hit, 2'b00, idx};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      rd(7'h41, rv); chk("R1 mask", rv, 32'h0);
      chk("R1 irq_n", {31'b0, irq_n}, 32'h1);
      rd(7'h05, rv); chk("R1 mode", rv, 32'h0);
      rd(7'h25, rv); chk("R1 vector", rv, 32'h0);
      rd(7'h40, rv); chk("R1 claim spurious", rv, 32'h0);

      // R3 external keeps all types; R4 internal coercion
      wr(7'h1C, 32'h35); rd(7'h1C, rv); chk("R3 ext mode", rv, 32'h35);
      wr(7'h03, 32'h22); rd(7'h03, rv); chk("R4 low->high", rv, 32'h02);
      wr(7'h03, 32'h32); rd(7'h03, rv); chk("R4 fall->rise", rv, 32'h12);
      wr(7'h1C, 32'h00); wr(7'h03, 32'h00);

      // R2 write-one enable and disable
      wr(7'h42, 32'h0000_00F0); wr(7'h42, 32'h0);
      rd(7'h41, rv); chk("R2 enable", rv, 32'h0000_00F0);
      wr(7'h43, 32'h0000_0030); wr(7'h43, 32'h0);
      rd(7'h41, rv); chk("R2 disable", rv, 32'h0000_00C0);
      wr(7'h43, 32'hFFFF_FFFF);

      // R6 spurious vector without push
      wr(7'h46, 32'h1234);
      rd(7'h40, rv); chk("R6 spurious", rv, 32'h1234);

      // R9 rising edge latch, clear by claim, by command, by all-ones
      wr(7'h05, 32'h14); wr(7'h25, 32'h505); wr(7'h42, 32'h20);
      src_in[5] = 1'b1; tick(3); src_in[5] = 1'b0; tick(4);
      chk("R9 edge latched", {31'b0, irq_n}, 32'h0);
      rd(7'h40, rv); chk("R5 edge claim", rv, 32'h505);
      wr(7'h45, 32'h0);
      chk("R9 claim clears", {31'b0, irq_n}, 32'h1);
      src_in[5] = 1'b1; tick(3); src_in[5] = 1'b0; tick(4);
      chk("R9 relatched", {31'b0, irq_n}, 32'h0);
      wr(7'h44, 32'h20);
      chk("R9 clear bit", {31'b0, irq_n}, 32'h1);
      src_in[5] = 1'b1; tick(3); src_in[5] = 1'b0; tick(4);
      wr(7'h44, 32'hFFFF_FFFF);
      chk("R9 clear all", {31'b0, irq_n}, 32'h1);
      wr(7'h43, 32'h20); wr(7'h05, 32'h0);

      // R9 falling edge on external source 29
      src_in[29] = 1'b1; tick(4);
      wr(7'h1D, 32'h36); wr(7'h3D, 32'h29); wr(7'h42, 32'h2000_0000);
      chk("R9 fall idle", {31'b0, irq_n}, 32'h1);
      src_in[29] = 1'b0; tick(4);
      chk("R9 fall latched", {31'b0, irq_n}, 32'h0);
      rd(7'h40, rv); chk("R5 fall claim", rv, 32'h29);
      wr(7'h45, 32'h0);
      wr(7'h43, 32'h2000_0000); wr(7'h1D, 32'h0);

      // R10 level-low on external source 30, sync latency, no latching
      src_in[30] = 1'b1; tick(4);
      wr(7'h1E, 32'h21); wr(7'h3E, 32'h30); wr(7'h42, 32'h4000_0000);
      chk("R10 low idle", {31'b0, irq_n}, 32'h1);
      src_in[30] = 1'b0; tick(1);
      chk("R10 one cycle", {31'b0, irq_n}, 32'h1);
      tick(1);
      chk("R10 two cycles", {31'b0, irq_n}, 32'h0);
      src_in[30] = 1'b1; tick(3);
      chk("R10 released", {31'b0, irq_n}, 32'h1);
      wr(7'h43, 32'h4000_0000); wr(7'h1E, 32'h0);

      // R5 priority, tie to lowest index; R7 masking by stack; R8 pop
      wr(7'h08, 32'h03); wr(7'h09, 32'h03); wr(7'h0A, 32'h06);
      wr(7'h28, 32'h80); wr(7'h29, 32'h90); wr(7'h2A, 32'hA0);
      wr(7'h42, 32'h700); src_in[10:8] = 3'b111; tick(3);
      chk("R7 level request", {31'b0, irq_n}, 32'h0);
      rd(7'h40, rv); chk("R5 highest prio", rv, 32'hA0);
      chk("R7 masked by stack", {31'b0, irq_n}, 32'h1);
      rd(7'h40, rv); chk("R6 no push claim", rv, 32'h1234);
      wr(7'h45, 32'h0);
      chk("R8 pop reopens", {31'b0, irq_n}, 32'h0);
      src_in[10] = 1'b0; tick(3);
      rd(7'h40, rv); chk("R5 tie lowest idx", rv, 32'h80);
      chk("R7 equal prio blocked", {31'b0, irq_n}, 32'h1);
      wr(7'h45, 32'h0);
      src_in[10:8] = 3'b000; wr(7'h43, 32'h700); tick(3);

      // R8 eight nested levels
      for (int p = 0; p < 8; p++) begin
         wr(7'(16 + p), 32'(p)); wr(7'(48 + p), 32'h100 + 32'(p));
      end
      src_in[23:16] = 8'hFF; tick(3);
      for (int p = 0; p < 8; p++) begin
         wr(7'h42, 32'h1 << (16 + p));
         rd(7'h40, rv); chk("R8 nested claim", rv, 32'h100 + 32'(p));
      end
      chk("R8 full stack", {31'b0, irq_n}, 32'h1);
      wr(7'h43, 32'h00FF_0000);
      for (int k = 0; k < 7; k++) wr(7'h45, 32'h0);
      wr(7'h42, 32'h0001_0000);
      chk("R8 seven pops", {31'b0, irq_n}, 32'h1);
      wr(7'h45, 32'h0);
      chk("R8 eight pops", {31'b0, irq_n}, 32'h0);
      wr(7'h45, 32'h0);
      rd(7'h40, rv); chk("R8 extra pop ignored", rv, 32'h100);
      chk("R8 push after empty", {31'b0, irq_n}, 32'h1);
      wr(7'h45, 32'h0);
      wr(7'h43, 32'hFFFF_FFFF); src_in = '0; tick(3);

      // random level-high traffic on internal sources 0..15
      b_mask = '0; b_stk = '0;
      for (int i = 0; i < 16; i++) begin
         b_prio[i] = 3'($urandom % 8); b_vec[i] = $urandom & 32'hFFFF;
         wr(7'(i), 32'(b_prio[i])); wr(7'(32 + i), b_vec[i]);
      end
      for (int it = 0; it < 150; it++) begin
         int j;
         logic [15:0] m;
         logic [7:0]  s;
         j = int'($urandom % 16);
         b_prio[j] = 3'($urandom % 8); wr(7'(j), 32'(b_prio[j]));
         m = 16'($urandom); wr(7'h42, 32'(m)); b_mask |= m;
         m = 16'($urandom & $urandom); wr(7'h43, 32'(m)); b_mask &= ~m;
         src_in[15:0] = 16'($urandom); tick(3);
         s = model_sel(src_in[15:0] & b_mask);
         chk("R7 random irq", {31'b0, irq_n}, {31'b0, ~s[7]});
         rd(7'h40, rv);
         chk("R5 random claim", rv, s[7] ? b_vec[s[3:0]] : 32'h1234);
         if (s[7]) b_stk[b_prio[s[3:0]]] = 1'b1;
         if ($urandom % 2 == 0) begin
            wr(7'h45, 32'h0);
            for (int l = 7; l >= 0; l--)
               if (b_stk[l]) begin b_stk[l] = 1'b0; break; end
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule